// File: doc/BRIEF.md
# Auto-Exposure Hysteresis Controller

This block regulates a 16-bit exposure value from a stream of per-frame average luminance samples. Each sample is an 8-bit integer. The block widens it to 8.8 fixed point and compares it with a programmable 8-bit target. A correction begins only when the absolute error is larger than an outer threshold (the start band). After that, every evaluated sample moves the exposure until the error falls to or below an inner threshold (the stop band). Each move is the error multiplied by an 8.8 scale factor and shifted right by 8. Its sign follows the direction of the error, and the result saturates at 0 and at 65535.

Evaluations are rate-limited by a programmable period counter. Configuration uses a single-cycle write port with a combinational read-back of the addressed field.

The luminance samples arrive on a valid/ready stream. `luma_ready` is held high at all times, so the block never applies back-pressure. A sample counts as accepted on any clock edge where `luma_valid` is high. An accepted sample is evaluated only if the period counter has expired; otherwise it is consumed and discarded. The `correcting` pin shows the latched correction state.

Top module: `ae_hyst_ctrl`

## Requirements
- R1: After reset, the fields read back as follows: target 105 at address 0, start band 0x0300 (3.0) at address 1, stop band 0x0100 (1.0) at address 2, step scale 0x6400 (100.0) at address 3, and update period 3000 at address 4. Addresses 5 to 7 read 0.
- R2: A write to addresses 1 to 4 replaces the whole 16-bit field, and the new value reads back unchanged. A write to address 0 keeps only bits 7:0, and bits 15:8 of that field read as 0.
- R3: After reset, `exposure` equals the parameter EXP_INIT (default 4096) and `correcting` is 0.
- R4: While `correcting` is 0, an evaluated sample whose error |target − luma|·256 is strictly greater than the start band sets `correcting` and applies a step at the same edge. An error equal to or below the start band leaves both outputs unchanged.
- R5: While `correcting` is 1, an evaluated sample whose error is at or below the stop band clears `correcting` and leaves `exposure` unchanged. Any larger error applies a step and keeps `correcting` at 1.
- R6: A step has magnitude (|target − luma|·256 · scale) >> 8. It raises `exposure` when luma is below the target and lowers it when luma is above the target.
- R7: Exposure saturates at 65535 on a raise and at 0 on a lower.
- R8: With period P, after an evaluation the next accepted sample is evaluated no earlier than P+1 clock edges later. Samples accepted in between change neither output.
- R9: With period 0, every accepted sample is evaluated. The first sample after reset is always evaluated.
- R10: `luma_ready` is 1 in every cycle after reset, and both outputs change only on an edge that evaluates a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration field at cfg_addr |
| cfg_addr | input | 3 | Field select: 0 target, 1 start band, 2 stop band, 3 scale, 4 period |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current value of the field at cfg_addr |
| luma_valid | input | 1 | Luminance sample present |
| luma_ready | output | 1 | Sample accepted (always 1) |
| luma_data | input | 8 | Average luminance of the frame |
| exposure | output | 16 | Exposure value |
| correcting | output | 1 | 1 while a correction is latched |

## Verification
A wrong latched state shows up at the next evaluated sample. A sample whose error lies between the two bands either moves `exposure` when it should not, or leaves it still when it should move; that edge is where the mismatch appears. Sweeps over many luminance values across several target and band settings therefore expose a wrong band comparison, a wrong step sign or size, or a missing clamp, each on the first sample that reaches it. A miscounting period timer shows up when a stream of continuous valid samples yields an exposure change one edge early or one edge late.

// File: rtl/ae_pkg.sv
package ae_pkg;
  localparam int AE_DATA_W = 16;
  localparam int AE_LUMA_W = 8;
  localparam int AE_FRAC_W = 8;
  localparam int AE_ADDR_W = 3;

  localparam logic [AE_ADDR_W-1:0] AE_A_TARGET = 3'd0;
  localparam logic [AE_ADDR_W-1:0] AE_A_START  = 3'd1;
  localparam logic [AE_ADDR_W-1:0] AE_A_STOP   = 3'd2;
  localparam logic [AE_ADDR_W-1:0] AE_A_SCALE  = 3'd3;
  localparam logic [AE_ADDR_W-1:0] AE_A_PERIOD = 3'd4;

  typedef enum logic {AE_IDLE = 1'b0, AE_CORRECT = 1'b1} ae_state_e;

  typedef struct packed {
    logic [AE_LUMA_W-1:0] target;
    logic [AE_DATA_W-1:0] start_band;
    logic [AE_DATA_W-1:0] stop_band;
    logic [AE_DATA_W-1:0] scale;
    logic [AE_DATA_W-1:0] period;
  } ae_cfg_t;
endpackage

// File: rtl/ae_cfg_regs.sv
module ae_cfg_regs
  import ae_pkg::*;
#(
  parameter logic [AE_LUMA_W-1:0] TARGET_RST = 8'd105,
  parameter logic [AE_DATA_W-1:0] START_RST  = 16'h0300,
  parameter logic [AE_DATA_W-1:0] STOP_RST   = 16'h0100,
  parameter logic [AE_DATA_W-1:0] SCALE_RST  = 16'h6400,
  parameter logic [AE_DATA_W-1:0] PERIOD_RST = 16'd3000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AE_ADDR_W-1:0] addr,
  input  logic [AE_DATA_W-1:0] wdata,
  output logic [AE_DATA_W-1:0] rdata,
  output ae_cfg_t              cfg
);
  localparam int PAD_W = AE_DATA_W - AE_LUMA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.target     <= TARGET_RST;
      cfg.start_band <= START_RST;
      cfg.stop_band  <= STOP_RST;
      cfg.scale      <= SCALE_RST;
      cfg.period     <= PERIOD_RST;
    end else if (wr_en) begin
      case (addr)
        AE_A_TARGET: cfg.target     <= wdata[AE_LUMA_W-1:0];
        AE_A_START:  cfg.start_band <= wdata;
        AE_A_STOP:   cfg.stop_band  <= wdata;
        AE_A_SCALE:  cfg.scale      <= wdata;
        AE_A_PERIOD: cfg.period     <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      AE_A_TARGET: rdata = {{PAD_W{1'b0}}, cfg.target};
      AE_A_START:  rdata = cfg.start_band;
      AE_A_STOP:   rdata = cfg.stop_band;
      AE_A_SCALE:  rdata = cfg.scale;
      AE_A_PERIOD: rdata = cfg.period;
      default:     rdata = '0;
    endcase
  end

  // R2: a write lands in the addressed field on the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AE_A_SCALE) |=> cfg.scale == $past(wdata));
endmodule

// File: rtl/ae_period_timer.sv
module ae_period_timer
  import ae_pkg::*;
#(
  parameter int CNT_W = AE_DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             fire,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (fire)         cnt_q <= period;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R8: every evaluation reloads the wait from the programmed period
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == $past(period));
  // R9: a zero period leaves the timer expired after an evaluation
  a_r9_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && period == '0) |=> expired);
endmodule

// File: rtl/ae_step_calc.sv
module ae_step_calc
  import ae_pkg::*;
#(
  parameter int LUMA_W = AE_LUMA_W,
  parameter int DATA_W = AE_DATA_W,
  parameter int FRAC_W = AE_FRAC_W
) (
  input  logic [LUMA_W-1:0] target,
  input  logic [LUMA_W-1:0] luma,
  input  logic [DATA_W-1:0] scale,
  input  logic [DATA_W-1:0] exposure,
  output logic [DATA_W-1:0] err_mag,
  output logic              raise,
  output logic [DATA_W-1:0] exp_next
);
  localparam int PROD_W = 2 * DATA_W;
  localparam logic [PROD_W-1:0] EXP_MAX = {{DATA_W{1'b0}}, {DATA_W{1'b1}}};

  logic [LUMA_W-1:0] mag;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] step_w;
  logic [PROD_W-1:0] exp_w;
  logic [PROD_W-1:0] sum_w;

  always_comb begin
    raise   = (target > luma);
    mag     = raise ? (target - luma) : (luma - target);
    err_mag = {mag, {FRAC_W{1'b0}}};
    product = PROD_W'(err_mag) * PROD_W'(scale);
    step_w  = product >> FRAC_W;
    exp_w   = PROD_W'(exposure);
    sum_w   = exp_w + step_w;
    if (raise) begin
      exp_next = (sum_w > EXP_MAX) ? {DATA_W{1'b1}} : sum_w[DATA_W-1:0];
    end else if (step_w > exp_w) begin
      exp_next = '0;
    end else begin
      exp_next = exposure - step_w[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/ae_ctrl_fsm.sv
module ae_ctrl_fsm
  import ae_pkg::*;
#(
  parameter int                DATA_W   = AE_DATA_W,
  parameter logic [DATA_W-1:0] EXP_INIT = 16'd4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [DATA_W-1:0] err_mag,
  input  logic [DATA_W-1:0] start_band,
  input  logic [DATA_W-1:0] stop_band,
  input  logic [DATA_W-1:0] exp_next,
  output logic [DATA_W-1:0] exposure,
  output logic              correcting
);
  ae_state_e state_q, state_d;
  logic [DATA_W-1:0] exp_q, exp_d;

  always_comb begin
    state_d = state_q;
    exp_d   = exp_q;
    if (eval) begin
      case (state_q)
        AE_IDLE: begin
          if (err_mag > start_band) begin
            state_d = AE_CORRECT;
            exp_d   = exp_next;
          end
        end
        AE_CORRECT: begin
          if (err_mag <= stop_band) begin
            state_d = AE_IDLE;
          end else begin
            exp_d = exp_next;
          end
        end
        default: state_d = AE_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= AE_IDLE;
      exp_q   <= EXP_INIT;
    end else begin
      state_q <= state_d;
      exp_q   <= exp_d;
    end
  end

  assign exposure   = exp_q;
  assign correcting = (state_q == AE_CORRECT);

  // R4: inside the start band an idle controller stays put
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !correcting && err_mag <= start_band) |=> (!correcting && $stable(exposure)));
  // R4: beyond the start band correction latches
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !correcting && err_mag > start_band) |=> correcting);
  // R5: within the stop band correction ends without a step
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && correcting && err_mag <= stop_band) |=> (!correcting && $stable(exposure)));
endmodule

// File: rtl/ae_hyst_ctrl.sv
module ae_hyst_ctrl
  import ae_pkg::*;
#(
  parameter logic [AE_DATA_W-1:0] EXP_INIT = 16'd4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [AE_ADDR_W-1:0] cfg_addr,
  input  logic [AE_DATA_W-1:0] cfg_wdata,
  output logic [AE_DATA_W-1:0] cfg_rdata,
  input  logic                 luma_valid,
  output logic                 luma_ready,
  input  logic [AE_LUMA_W-1:0] luma_data,
  output logic [AE_DATA_W-1:0] exposure,
  output logic                 correcting
);
  ae_cfg_t              cfg;
  logic                 expired;
  logic                 eval;
  logic                 raise;
  logic [AE_DATA_W-1:0] err_mag;
  logic [AE_DATA_W-1:0] exp_next;

  assign luma_ready = 1'b1;
  assign eval       = luma_valid && luma_ready && expired;

  ae_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  ae_period_timer #(.CNT_W(AE_DATA_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (cfg.period),
    .fire    (eval),
    .expired (expired)
  );

  ae_step_calc u_step (
    .target   (cfg.target),
    .luma     (luma_data),
    .scale    (cfg.scale),
    .exposure (exposure),
    .err_mag  (err_mag),
    .raise    (raise),
    .exp_next (exp_next)
  );

  ae_ctrl_fsm #(.DATA_W(AE_DATA_W), .EXP_INIT(EXP_INIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (eval),
    .err_mag    (err_mag),
    .start_band (cfg.start_band),
    .stop_band  (cfg.stop_band),
    .exp_next   (exp_next),
    .exposure   (exposure),
    .correcting (correcting)
  );

  // R10: outputs move only on an evaluating edge
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(exposure) && $stable(correcting)));
  // R6: a dark frame never lowers the exposure
  a_r6_raise_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && raise) |=> exposure >= $past(exposure));
  // R6: a bright frame never raises the exposure
  a_r6_lower_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !raise) |=> exposure <= $past(exposure));
  // R8: a sample arriving before expiry is discarded
  a_r8_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (luma_valid && !expired) |=> $stable(exposure));
endmodule

// File: tb/ae_hyst_ctrl_bench.sv
module ae_hyst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        luma_valid = 1'b0;
  logic        luma_ready;
  logic [7:0]  luma_data = '0;
  logic [15:0] exposure;
  logic        correcting;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_t, m_h, m_l, m_s, m_exp;
  bit m_st;

  always #5 clk = ~clk;

  ae_hyst_ctrl u_ae_hyst_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .luma_valid(luma_valid),
    .luma_ready(luma_ready), .luma_data(luma_data), .exposure(exposure),
    .correcting(correcting)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    case (a)
      0: m_t = d & 255;
      1: m_h = d;
      2: m_l = d;
      3: m_s = d;
      default: ;
    endcase
  endtask

  task automatic rd_check(string req, int a, int exp);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 check(req, int'(cfg_rdata), exp);
  endtask

  task automatic model_eval(int m);
    int d, err, stp;
    d   = (m_t > m) ? (m_t - m) : (m - m_t);
    err = d * 256;
    stp = d * m_s;
    if ((!m_st && err > m_h) || (m_st && err > m_l)) begin
      m_st = 1'b1;
      if (m_t > m) m_exp = (m_exp + stp > 65535) ? 65535 : m_exp + stp;
      else         m_exp = (stp > m_exp) ? 0 : m_exp - stp;
    end else if (m_st) begin
      m_st = 1'b0;
    end
  endtask

  // one sample with period 0: evaluated at the next edge
  task automatic send(string req, int m);
    @(negedge clk);
    luma_valid = 1'b1; luma_data = 8'(m);
    @(posedge clk);
    #1 luma_valid = 1'b0;
    model_eval(m);
    @(negedge clk);
    check(req, int'(exposure), m_exp);
    check(req, int'(correcting), int'(m_st));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    m_t = 105; m_h = 'h300; m_l = 'h100; m_s = 'h6400; m_exp = 4096; m_st = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3 reset outputs, R10 ready
    @(negedge clk);
    check("R3 exposure", int'(exposure), 4096);
    check("R3 correcting", int'(correcting), 0);
    check("R10 ready", int'(luma_ready), 1);

    // R1 defaults
    rd_check("R1 target", 0, 105);
    rd_check("R1 start", 1, 'h0300);
    rd_check("R1 stop", 2, 'h0100);
    rd_check("R1 scale", 3, 'h6400);
    rd_check("R1 period", 4, 3000);
    for (int a = 5; a < 8; a++) rd_check("R1 unmapped", a, 0);

    // R2 write/readback
    wr(0, 'hABCD); rd_check("R2 target width", 0, 'hCD);
    wr(1, 'h1234); rd_check("R2 start", 1, 'h1234);
    wr(2, 'hFEDC); rd_check("R2 stop", 2, 'hFEDC);
    wr(3, 'h0F0F); rd_check("R2 scale", 3, 'h0F0F);
    wr(4, 0);      rd_check("R2 period", 4, 0);

    // R9 first sample after reset evaluated (period was 3000, timer starts expired)
    // covered below: period now 0, all samples evaluated

    // R4/R5 directed band edges: target 100, start 3.0, stop 1.0, scale 1/16
    wr(0, 100); wr(1, 'h0300); wr(2, 'h0100); wr(3, 'h0010);
    send("R4 err equal start band", 97);
    send("R4 err equal start band high", 103);
    send("R4 start beyond band", 96);
    send("R5 continue above stop", 98);
    send("R5 continue above stop high", 102);
    send("R5 stop at stop band", 99);
    send("R4 idle inside start band", 102);
    send("R6 raise step", 90);
    send("R6 lower step", 120);
    send("R5 stop exact target", 100);

    // R4 R5 R6 R9 sweeps over several band and scale settings
    for (int cfgi = 0; cfgi < 4; cfgi++) begin
      wr(0, 40 + cfgi * 55);
      wr(1, 'h0200 + cfgi * 'h0380);
      wr(2, 'h0080 + cfgi * 'h0100);
      wr(3, 'h0008 + cfgi * 'h0011);
      for (int i = 0; i < 300; i++)
        send("R6 sweep", (i * 37 + cfgi * 11 + ((i / 7) % 5) * 3) % 256);
    end

    // R7 saturation
    wr(0, 255); wr(3, 'hFFFF); wr(1, 'h0100);
    send("R7 clamp high", 0);
    send("R7 hold high", 0);
    wr(0, 0);
    send("R7 clamp low", 255);
    send("R7 hold low", 255);

    // R8 period pacing: period 4, continuous valid samples, step 255
    wr(0, 255); wr(3, 'h0001); wr(4, 4);
    @(negedge clk);
    luma_valid = 1'b1; luma_data = 8'd0;
    for (int k = 0; k < 15; k++) begin
      @(posedge clk);
      if (k % 5 == 0) model_eval(0);
      @(negedge clk);
      check("R8 paced exposure", int'(exposure), m_exp);
      check("R8 paced state", int'(correcting), int'(m_st));
    end
    luma_valid = 1'b0;
    wr(4, 0);
    repeat (8) @(posedge clk);
    send("R9 period zero again", 10);
    send("R9 back to back", 20);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule